// File: doc/BRIEF.md
# Multi-Window Address Claim Decoder

This block decides which device, if any, owns an incoming memory or I/O transaction. It is given a set of address windows, one per base register of each attached device, each described by a base, a size and a 2-bit type code. It compares the request address against all windows in parallel and picks the first match in a fixed priority order. It then reports a claim flag, the device and register index of the winner, and the offset of the address inside that window.

For reads it also returns the winning device's read data. A read that no window claims returns zero. All results are registered and appear one clock after the request. The controller above feeds the windows in index order, where index = device * NUM_BAR + register. Devices are numbered by bus number first and then by device number, so lower bus and device numbers take precedence.

Top module: `addr_claim_decoder`

## Requirements
- R1: A window covers addresses from base up to, but not including, base + size. The base address matches and base + size does not. The sum is taken without wraparound.
- R2: A window whose size is zero never claims an access.
- R3: When several windows match, the one with the lowest index claims the access. The index is device * NUM_BAR + register, with devices numbered by bus first and then by device number.
- R4: For a memory access (reqSpace = 0), a window takes part only when bit 0 of its type is 0, so types 2'b00 and 2'b10 take part. All other windows are ignored.
- R5: For an I/O access (reqSpace = 1), a window takes part only when its type equals 2'b01 exactly. Type 2'b11 never claims.
- R6: On a claim, rspOffset equals the request address minus the base of the claiming window. rspDev and rspBar give the winner's device and register index.
- R7: An access that no window claims reports rspClaim = 0, with rspDev, rspBar, rspOffset and rspData all zero.
- R8: A claimed read returns the claiming device's slice of devRdData on rspData. A claimed write returns zero on rspData.
- R9: The results appear with rspValid = 1 on the cycle after reqValid is sampled high. When no request was sampled, rspValid is 0 and all result outputs are zero.
- R10: During and after reset, and before the first request, rspValid and rspClaim are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is present this cycle |
| reqSpace | input | 1 | 0 = memory space, 1 = I/O space |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| winBase | input | NUM_WIN*ADDR_W | Window bases, window w in slice w |
| winSize | input | NUM_WIN*ADDR_W | Window sizes in bytes |
| winType | input | NUM_WIN*2 | Window type codes |
| devRdData | input | NUM_DEV*DATA_W | Read data of each device, device d in slice d |
| rspValid | output | 1 | Result valid |
| rspClaim | output | 1 | The access was claimed |
| rspDev | output | DEV_W | Device index of the winner |
| rspBar | output | BAR_W | Register index of the winner |
| rspOffset | output | ADDR_W | Address minus winner base |
| rspData | output | DATA_W | Read data, or zero |

## Verification
The bench probes both ends of a window: the base address, the last byte inside, and the first address past the end. A decoder that used an inclusive upper bound would claim that last address. Two overlapping memory windows check priority, because swapping the order hands the overlap to the later device and changes the offset. An I/O window and a memory window share one base. Further windows carry types 2'b11 and 2'b10 and a zero size. These expose a decoder that tests only bit 0 for I/O, that ignores the space input, or that lets an empty window claim. Unclaimed reads and claimed writes check that stale device data never leaks onto rspData.

// File: rtl/addr_claim_pkg.sv
package addr_claim_pkg;

  localparam logic [1:0] TYPE_IO   = 2'b01;
  localparam logic       SPACE_MEM = 1'b0;
  localparam logic       SPACE_IO  = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a fresh decode result
    logic clear;  // drive the result registers to zero
  } claimStrobe_t;

  function automatic int unsigned atLeastOne(input int unsigned v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/addr_claim_ctrl.sv
module addr_claim_ctrl
  import addr_claim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output claimStrobe_t strobe,
  output logic         rspValid
);

  always_comb begin
    strobe.load  = reqValid;
    strobe.clear = !reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R9

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);  // R9

endmodule

// File: rtl/addr_claim_dp.sv
module addr_claim_dp
  import addr_claim_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned NUM_BAR = 2,
  localparam int unsigned NUM_WIN = NUM_DEV * NUM_BAR,
  localparam int unsigned DEV_W   = atLeastOne($clog2(NUM_DEV)),
  localparam int unsigned BAR_W   = atLeastOne($clog2(NUM_BAR))
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  claimStrobe_t              strobe,
  input  logic                      reqSpace,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [NUM_WIN*ADDR_W-1:0] winBase,
  input  logic [NUM_WIN*ADDR_W-1:0] winSize,
  input  logic [NUM_WIN*2-1:0]      winType,
  input  logic [NUM_DEV*DATA_W-1:0] devRdData,
  output logic                      rspClaim,
  output logic [DEV_W-1:0]          rspDev,
  output logic [BAR_W-1:0]          rspBar,
  output logic [ADDR_W-1:0]         rspOffset,
  output logic [DATA_W-1:0]         rspData
);

  logic [NUM_WIN-1:0] hitVec;
  logic [NUM_WIN-1:0] grantVec;
  logic               anyHit;
  logic [ADDR_W-1:0]  selBase;
  logic [DEV_W-1:0]   selDev;
  logic [BAR_W-1:0]   selBar;
  logic [DATA_W-1:0]  selData;

  // per-window comparators
  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    logic [1:0]        wType;
    logic              eligible;
    logic              inRange;

    assign base  = winBase[g*ADDR_W +: ADDR_W];
    assign size  = winSize[g*ADDR_W +: ADDR_W];
    assign wType = winType[g*2 +: 2];

    assign eligible = (reqSpace == SPACE_IO) ? (wType == TYPE_IO) : (wType[0] == 1'b0);
    assign inRange  = ({1'b0, reqAddr} >= {1'b0, base}) &&
                      ({1'b0, reqAddr} <  ({1'b0, base} + {1'b0, size}));
    assign hitVec[g] = eligible && inRange && (size != '0);

    AST_EMPTY_NEVER_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
      grantVec[g] |-> (size != '0));  // R2
  end

  // priority pick: lowest index wins
  always_comb begin
    grantVec = '0;
    anyHit   = 1'b0;
    selBase  = '0;
    selDev   = '0;
    selBar   = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hitVec[i] && !anyHit) begin
        grantVec[i] = 1'b1;
        anyHit      = 1'b1;
        selBase     = winBase[i*ADDR_W +: ADDR_W];
        selDev      = DEV_W'(i / NUM_BAR);
        selBar      = BAR_W'(i % NUM_BAR);
      end
    end
  end

  always_comb begin
    selData = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (selDev == DEV_W'(d)) selData = devRdData[d*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspClaim  <= 1'b0;
      rspDev    <= '0;
      rspBar    <= '0;
      rspOffset <= '0;
      rspData   <= '0;
    end else if (strobe.load) begin
      rspClaim  <= anyHit;
      rspDev    <= selDev;
      rspBar    <= selBar;
      rspOffset <= anyHit ? (reqAddr - selBase) : '0;
      rspData   <= (anyHit && !reqWrite) ? selData : '0;
    end else if (strobe.clear) begin
      rspClaim  <= 1'b0;
      rspDev    <= '0;
      rspBar    <= '0;
      rspOffset <= '0;
      rspData   <= '0;
    end
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));  // R3

  AST_UNCLAIMED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rspClaim |-> (rspOffset == '0 && rspData == '0 && rspDev == '0 && rspBar == '0));  // R7

endmodule

// File: rtl/addr_claim_decoder.sv
module addr_claim_decoder
  import addr_claim_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned NUM_BAR = 2,
  localparam int unsigned NUM_WIN = NUM_DEV * NUM_BAR,
  localparam int unsigned DEV_W   = atLeastOne($clog2(NUM_DEV)),
  localparam int unsigned BAR_W   = atLeastOne($clog2(NUM_BAR))
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqSpace,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [NUM_WIN*ADDR_W-1:0] winBase,
  input  logic [NUM_WIN*ADDR_W-1:0] winSize,
  input  logic [NUM_WIN*2-1:0]      winType,
  input  logic [NUM_DEV*DATA_W-1:0] devRdData,
  output logic                      rspValid,
  output logic                      rspClaim,
  output logic [DEV_W-1:0]          rspDev,
  output logic [BAR_W-1:0]          rspBar,
  output logic [ADDR_W-1:0]         rspOffset,
  output logic [DATA_W-1:0]         rspData
);

  claimStrobe_t strobe;

  addr_claim_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  addr_claim_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_DEV (NUM_DEV),
    .NUM_BAR (NUM_BAR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqSpace  (reqSpace),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .winBase   (winBase),
    .winSize   (winSize),
    .winType   (winType),
    .devRdData (devRdData),
    .rspClaim  (rspClaim),
    .rspDev    (rspDev),
    .rspBar    (rspBar),
    .rspOffset (rspOffset),
    .rspData   (rspData)
  );

  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid ##1 rspClaim) |-> (rspOffset <= $past(reqAddr)));  // R6

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspClaim);  // R9

endmodule

// File: tb/addr_claim_decoder_bench.sv
`timescale 1ns/1ps
module addr_claim_decoder_bench;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int ND = 4;
  localparam int NB = 2;
  localparam int NW = ND * NB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqSpace = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [NW*AW-1:0] winBase;
  logic [NW*AW-1:0] winSize;
  logic [NW*2-1:0]  winType;
  logic [ND*DW-1:0] devRdData;
  logic          rspValid, rspClaim;
  logic [1:0]    rspDev;
  logic [0:0]    rspBar;
  logic [AW-1:0] rspOffset;
  logic [DW-1:0] rspData;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  addr_claim_decoder #(.ADDR_W(AW), .DATA_W(DW), .NUM_DEV(ND), .NUM_BAR(NB)) u_addr_claim_decoder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSpace(reqSpace), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .winBase(winBase), .winSize(winSize), .winType(winType),
    .devRdData(devRdData), .rspValid(rspValid), .rspClaim(rspClaim), .rspDev(rspDev),
    .rspBar(rspBar), .rspOffset(rspOffset), .rspData(rspData)
  );

  function automatic logic [DW-1:0] devWord(input int d);
    case (d)
      0: return 32'hA0A0_A0A0;
      1: return 32'hB1B1_B1B1;
      2: return 32'hC2C2_C2C2;
      default: return 32'hD3D3_D3D3;
    endcase
  endfunction

  task automatic setWin(input int w, input logic [AW-1:0] b, input logic [AW-1:0] s, input logic [1:0] t);
    winBase[w*AW +: AW] = b;
    winSize[w*AW +: AW] = s;
    winType[w*2 +: 2]   = t;
  endtask

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // send one request, then compare the registered result
  task automatic probe(input string req, input logic space, input logic wr, input logic [AW-1:0] addr,
                       input logic expClaim, input int expDev, input int expBar,
                       input logic [AW-1:0] expOff, input logic [DW-1:0] expData);
    @(negedge clk);
    reqValid = 1'b1; reqSpace = space; reqWrite = wr; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    check(req, "valid",  {63'd0, rspValid}, 64'd1);
    check(req, "claim",  {63'd0, rspClaim}, {63'd0, expClaim});
    check(req, "dev",    {62'd0, rspDev},   64'(expDev));
    check(req, "bar",    {63'd0, rspBar},   64'(expBar));
    check(req, "offset", {32'd0, rspOffset}, {32'd0, expOff});
    check(req, "data",   {32'd0, rspData},   {32'd0, expData});
  endtask

  task automatic testReset();
    check("R10", "valid at reset", {63'd0, rspValid}, 64'd0);
    check("R10", "claim at reset", {63'd0, rspClaim}, 64'd0);
  endtask

  task automatic testRangeEdges();  // R1
    probe("R1", 1'b0, 1'b0, 32'h1000, 1'b1, 0, 0, 32'h0,  devWord(0));
    probe("R1", 1'b0, 1'b0, 32'h10FF, 1'b1, 0, 0, 32'hFF, devWord(0));
    probe("R1", 1'b0, 1'b0, 32'h1100, 1'b1, 1, 0, 32'h80, devWord(1));
    probe("R1", 1'b1, 1'b0, 32'h6007, 1'b1, 3, 1, 32'h7,  devWord(3));
    probe("R1", 1'b1, 1'b0, 32'h6008, 1'b0, 0, 0, 32'h0,  32'h0);
  endtask

  task automatic testZeroSize();  // R2
    probe("R2", 1'b0, 1'b0, 32'h4000, 1'b0, 0, 0, 32'h0, 32'h0);
  endtask

  task automatic testPriority();  // R3
    probe("R3", 1'b0, 1'b0, 32'h1090, 1'b1, 0, 0, 32'h90, devWord(0));
  endtask

  task automatic testMemTypes();  // R4
    probe("R4", 1'b0, 1'b0, 32'h5010, 1'b1, 2, 1, 32'h10, devWord(2));
    probe("R4", 1'b0, 1'b0, 32'h2004, 1'b1, 3, 0, 32'h4,  devWord(3));
    probe("R4", 1'b0, 1'b0, 32'h3004, 1'b0, 0, 0, 32'h0,  32'h0);
  endtask

  task automatic testIoTypes();  // R5
    probe("R5", 1'b1, 1'b0, 32'h2004, 1'b1, 0, 1, 32'h4, devWord(0));
    probe("R5", 1'b1, 1'b0, 32'h3004, 1'b0, 0, 0, 32'h0, 32'h0);
    probe("R5", 1'b1, 1'b0, 32'h1010, 1'b0, 0, 0, 32'h0, 32'h0);
  endtask

  task automatic testOffset();  // R6
    probe("R6", 1'b0, 1'b0, 32'h20FF, 1'b1, 3, 0, 32'hFF, devWord(3));
  endtask

  task automatic testUnclaimed();  // R7
    probe("R7", 1'b0, 1'b0, 32'h9000, 1'b0, 0, 0, 32'h0, 32'h0);
  endtask

  task automatic testWriteData();  // R8
    probe("R8", 1'b0, 1'b1, 32'h1004, 1'b1, 0, 0, 32'h4, 32'h0);
    probe("R8", 1'b0, 1'b0, 32'h1104, 1'b1, 1, 0, 32'h84, devWord(1));
  endtask

  task automatic testIdle();  // R9
    probe("R9", 1'b0, 1'b0, 32'h1000, 1'b1, 0, 0, 32'h0, devWord(0));
    @(negedge clk);
    check("R9", "valid idle",  {63'd0, rspValid}, 64'd0);
    check("R9", "claim idle",  {63'd0, rspClaim}, 64'd0);
    check("R9", "data idle",   {32'd0, rspData},  64'd0);
  endtask

  initial begin
    // types: 00/10 memory, 01 I/O, 11 neither
    setWin(0, 32'h1000, 32'h100, 2'b00);
    setWin(1, 32'h2000, 32'h10,  2'b01);
    setWin(2, 32'h1080, 32'h100, 2'b00);
    setWin(3, 32'h3000, 32'h20,  2'b11);
    setWin(4, 32'h4000, 32'h0,   2'b00);
    setWin(5, 32'h5000, 32'h40,  2'b10);
    setWin(6, 32'h2000, 32'h100, 2'b00);
    setWin(7, 32'h6000, 32'h8,   2'b01);
    for (int d = 0; d < ND; d++) devRdData[d*DW +: DW] = devWord(d);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRangeEdges();
    testZeroSize();
    testPriority();
    testMemTypes();
    testIoTypes();
    testOffset();
    testUnclaimed();
    testWriteData();
    testIdle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule